// File: doc/BRIEF.md
# Prescaled Reference-Compare Timer Pair

This block holds two 16-bit up-counters, each advancing on a tick made by a selectable clock source and a two-stage 8-bit divider. When a counter reaches the value held in its reference register, the timer raises a sticky match flag. The flag can drive that timer's own interrupt line. The counter then either returns to zero or keeps counting. Software controls both timers through one shared configuration byte and a plain write-strobe register bus with a combinational read port.

Typical use is a periodic interrupt. Software holds a timer in reset and stopped, then loads its divider, mode and reference. It releases the reset and then clears the stop bit. In the interrupt handler it clears the flag by writing a one to it. The second timer can instead count wraps of the first timer, which stretches the period without a wider counter.

Top module: `tmr_pair_top`

## Requirements
- R1: After `rst_n` is low, the configuration byte reads 0x22, so both timers are stopped. Every other timer register reads 0 and both interrupt lines are low.
- R2: In the configuration byte, timer 0 uses bit 0 as its reset bit and bit 1 as its stop bit. Timer 1 uses bit 4 as its reset bit and bit 5 as its stop bit. A set stop bit freezes the counter and the divider. Counting starts on the first clock edge after the bit is cleared.
- R3: While a timer's reset bit is set, its counter, divider state and match flag are held at zero. Its mode and reference registers keep their contents.
- R4: Mode bits 2:1 select the count source: 1 = one pulse per clock, 2 = one pulse per 16 clocks, 0 = cascade, 3 = no pulses. In cascade mode, timer 0 counts one-cycle pulses on `casc_in`. Timer 1 counts each wrap or restart of timer 0.
- R5: The counter advances once every (P+1)×(S+1) source pulses. P is the 8-bit prescale register and S is mode bits 15:8.
- R6: When mode bit 3 is set (restart), a tick that finds the counter equal to the reference loads zero instead of incrementing. The counter therefore runs 0..ref and repeats.
- R7: When mode bit 3 is clear (free-run), the counter passes the reference and rolls over from 0xFFFF to 0x0000. The match flag is set only by a tick that brings the counter to the reference value.
- R8: The match flag is event-register bit 1, and every other event bit reads 0. Writing a 1 to bit 1 clears the flag, and writing a 0 leaves it unchanged. A new match in the same cycle as a clearing write wins.
- R9: Each timer's interrupt line is high exactly while its match flag is set and its mode bit 4 is set.
- R10: Register map with `bus_addr[3]` as the timer index and `bus_addr[2:0]` as the offset. Offset 0 of timer 0 is the configuration byte; only bits 5,4,1,0 are kept. The other offsets are 1 = mode (bits 15:8 and 4:1 kept), 2 = reference, 3 = counter, 4 = event and 5 = prescale (8 bits). Unmapped offsets read 0.
- R11: A counter write loads the written value, unless the timer is held in reset. The write takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| casc_in | input | 1 | Cascade count pulse for timer 0 |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| tmr_irq | output | 2 | Interrupt line per timer |

## Verification
The divider is swept over every combination of four prescale values, three secondary values and both clock-driven sources. The count after a fixed number of clocks must equal the floor of cycles over the full division. This separates an off-by-one in either stage and a wrong slow-mode factor. The restart and free-run cases run with a small reference. They are sampled on the cycles just before and just after the match and the rollover, which tells compare-on-old from compare-on-new values. The cascade chain, the reset-versus-stop bit positions and the clear-by-one event semantics are each tried with patterns where the wrong choice gives a different count or flag value.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CW = 16;
  localparam int PW = 8;
  localparam int NT = 2;
  localparam int AW = 4;
  localparam int SLOW_DIV = 16;

  typedef enum logic [1:0] {
    SRC_CASC = 2'd0,
    SRC_INT  = 2'd1,
    SRC_SLOW = 2'd2,
    SRC_NONE = 2'd3
  } src_e;

  localparam logic [2:0] OFS_CFG  = 3'd0;
  localparam logic [2:0] OFS_MODE = 3'd1;
  localparam logic [2:0] OFS_REF  = 3'd2;
  localparam logic [2:0] OFS_CNT  = 3'd3;
  localparam logic [2:0] OFS_EVT  = 3'd4;
  localparam logic [2:0] OFS_PSR  = 3'd5;

  localparam logic [CW-1:0] MODE_MASK = 16'hFF1E;
  localparam int MB_RESTART = 3;
  localparam int MB_IE      = 4;
  localparam int MB_SPS     = 8;
  localparam int EVT_MATCH  = 1;
  localparam logic [7:0] CFG_MASK  = 8'h33;
  localparam logic [7:0] CFG_RESET = 8'h22;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
#(
  parameter int PSW  = PW,
  parameter int SDIV = SLOW_DIV
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           run,
  input  logic [1:0]     sel,
  input  logic           casc,
  input  logic [PSW-1:0] pri,
  input  logic [PSW-1:0] sec,
  output logic           tick
);
  localparam int SW = $clog2(SDIV);
  localparam logic [SW-1:0] SLAST = SW'(SDIV - 1);

  logic [SW-1:0]  sdiv_q, sdiv_d;
  logic [PSW-1:0] pcnt_q, pcnt_d;
  logic [PSW-1:0] scnt_q, scnt_d;
  logic           src_pulse;
  logic           p_hit;

  always_comb begin
    case (sel)
      SRC_INT:  src_pulse = run;
      SRC_SLOW: src_pulse = run && (sdiv_q == SLAST);
      SRC_CASC: src_pulse = run && casc;
      default:  src_pulse = 1'b0;
    endcase

    sdiv_d = sdiv_q;
    if (clr)
      sdiv_d = '0;
    else if (run && sel == SRC_SLOW)
      sdiv_d = (sdiv_q == SLAST) ? '0 : sdiv_q + 1'b1;

    p_hit  = src_pulse && (pcnt_q == pri);
    pcnt_d = pcnt_q;
    if (clr)
      pcnt_d = '0;
    else if (src_pulse)
      pcnt_d = p_hit ? '0 : pcnt_q + 1'b1;

    tick   = p_hit && (scnt_q == sec);
    scnt_d = scnt_q;
    if (clr)
      scnt_d = '0;
    else if (p_hit)
      scnt_d = (scnt_q == sec) ? '0 : scnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdiv_q <= '0;
      pcnt_q <= '0;
      scnt_q <= '0;
    end else begin
      sdiv_q <= sdiv_d;
      pcnt_q <= pcnt_d;
      scnt_q <= scnt_d;
    end
  end

  // R5: a counter tick only ever follows a source pulse
  a_r5_tick_needs_src: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> src_pulse);
  // R3: divider state cleared while held in reset
  a_r3_div_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pcnt_q == '0 && scnt_q == '0 && sdiv_q == '0));
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  input  logic          casc,
  input  logic          we_mode,
  input  logic          we_ref,
  input  logic          we_cnt,
  input  logic          we_evt,
  input  logic          we_psr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] mode_o,
  output logic [CW-1:0] ref_o,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] evt_o,
  output logic [PW-1:0] psr_o,
  output logic          wrap,
  output logic          irq
);
  logic [CW-1:0] mode_q, mode_d;
  logic [CW-1:0] ref_q, ref_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] psr_q, psr_d;
  logic          flag_q, flag_d;
  logic          tick;
  logic [CW-1:0] nxt;
  logic          match_set;

  tmr_prescale #(.PSW(PW), .SDIV(SLOW_DIV)) presc_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .run   (run),
    .sel   (mode_q[2:1]),
    .casc  (casc),
    .pri   (psr_q),
    .sec   (mode_q[MB_SPS +: PW]),
    .tick  (tick)
  );

  always_comb begin
    nxt       = (mode_q[MB_RESTART] && cnt_q == ref_q) ? '0 : cnt_q + 1'b1;
    match_set = tick && (nxt == ref_q);
    wrap      = tick && (nxt == '0);

    mode_d = we_mode ? (wdata & MODE_MASK) : mode_q;
    ref_d  = we_ref  ? wdata : ref_q;
    psr_d  = we_psr  ? wdata[PW-1:0] : psr_q;

    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (we_cnt)
      cnt_d = wdata;
    else if (tick)
      cnt_d = nxt;

    flag_d = flag_q;
    if (clr)
      flag_d = 1'b0;
    else
      flag_d = (flag_q && !(we_evt && wdata[EVT_MATCH])) || match_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ref_q  <= '0;
      cnt_q  <= '0;
      psr_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      ref_q  <= ref_d;
      cnt_q  <= cnt_d;
      psr_q  <= psr_d;
      flag_q <= flag_d;
    end
  end

  assign mode_o = mode_q;
  assign ref_o  = ref_q;
  assign cnt_o  = cnt_q;
  assign psr_o  = psr_q;
  assign evt_o  = CW'({flag_q, 1'b0});
  assign irq    = flag_q && mode_q[MB_IE];

  // R3: reset bit zeroes counter and flag
  a_r3_clr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_o == '0 && evt_o == '0));
  // R11/R2: counter moves only on a tick or a write
  a_r11_cnt_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !we_cnt && !clr) |=> $stable(cnt_o));
  // R8: a fresh flag needs a tick from the divider
  a_r8_flag_from_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_o[EVT_MATCH]) |-> $past(tick));
  // R2: a stopped timer never ticks
  a_r2_stop_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick);
endmodule

// File: rtl/tmr_pair_top.sv
module tmr_pair_top
  import tmr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          casc_in,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  output logic [NT-1:0] tmr_irq
);
  logic [7:0] cfg_q, cfg_d;
  logic       t_idx;
  logic [2:0] ofs;

  logic [CW-1:0] mode_w [NT];
  logic [CW-1:0] ref_w  [NT];
  logic [CW-1:0] cnt_w  [NT];
  logic [CW-1:0] evt_w  [NT];
  logic [PW-1:0] psr_w  [NT];
  logic [NT-1:0] wrap_w;
  logic [NT-1:0] casc_w;
  logic [NT-1:0] clr_w;
  logic [NT-1:0] run_w;

  assign t_idx = bus_addr[AW-1];
  assign ofs   = bus_addr[2:0];

  always_comb begin
    cfg_d = cfg_q;
    if (bus_we && !t_idx && ofs == OFS_CFG)
      cfg_d = bus_wdata[7:0] & CFG_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RESET;
    else        cfg_q <= cfg_d;
  end

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    logic hit;
    assign hit      = bus_we && (t_idx == 1'(i));
    assign clr_w[i] = cfg_q[4*i];
    assign run_w[i] = !cfg_q[4*i+1] && !cfg_q[4*i];
    if (i == 0) begin : g_ext
      assign casc_w[i] = casc_in;
    end else begin : g_chain
      assign casc_w[i] = wrap_w[i-1];
    end

    tmr_unit unit_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr_w[i]),
      .run     (run_w[i]),
      .casc    (casc_w[i]),
      .we_mode (hit && ofs == OFS_MODE),
      .we_ref  (hit && ofs == OFS_REF),
      .we_cnt  (hit && ofs == OFS_CNT),
      .we_evt  (hit && ofs == OFS_EVT),
      .we_psr  (hit && ofs == OFS_PSR),
      .wdata   (bus_wdata),
      .mode_o  (mode_w[i]),
      .ref_o   (ref_w[i]),
      .cnt_o   (cnt_w[i]),
      .evt_o   (evt_w[i]),
      .psr_o   (psr_w[i]),
      .wrap    (wrap_w[i]),
      .irq     (tmr_irq[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    case (ofs)
      OFS_CFG:  bus_rdata = t_idx ? '0 : CW'(cfg_q);
      OFS_MODE: bus_rdata = mode_w[t_idx];
      OFS_REF:  bus_rdata = ref_w[t_idx];
      OFS_CNT:  bus_rdata = cnt_w[t_idx];
      OFS_EVT:  bus_rdata = evt_w[t_idx];
      OFS_PSR:  bus_rdata = CW'(psr_w[t_idx]);
      default:  bus_rdata = '0;
    endcase
  end

  // R4: timer 1 in cascade mode moves only when timer 0 wraps or is written
  a_r4_chain: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_w[1][2:1] == 2'd0 && !wrap_w[0] && !(bus_we && t_idx && ofs == OFS_CNT)
     && !clr_w[1]) |=> $stable(cnt_w[1]));
endmodule

// File: tb/tmr_pair_top_tb.sv
module tmr_pair_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] A_CFG = 4'h0;
  localparam logic [3:0] A_MODE0 = 4'h1, A_REF0 = 4'h2, A_CNT0 = 4'h3, A_EVT0 = 4'h4, A_PSR0 = 4'h5;
  localparam logic [3:0] A_MODE1 = 4'h9, A_REF1 = 4'hA, A_CNT1 = 4'hB;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        casc_in = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [1:0]  tmr_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_pair_top dut_i (
    .clk(clk), .rst_n(rst_n), .casc_in(casc_in), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tmr_irq(tmr_irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] mk_mode(input int sps, input bit ie, input bit rs, input int sel);
    return 16'((sps << 8) | (int'(ie) << 4) | (int'(rs) << 3) | (sel << 1));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, v2;
    #(CLK_PERIOD*3);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd(A_CFG, v);  chk("R1 cfg", v, 16'h0022);
    rd(A_MODE0, v); chk("R1 mode0", v, 16'h0);
    rd(A_CNT0, v); chk("R1 cnt0", v, 16'h0);
    rd(A_EVT0, v); chk("R1 evt0", v, 16'h0);
    rd(A_PSR0, v); chk("R1 psr0", v, 16'h0);
    rd(A_REF1, v); chk("R1 ref1", v, 16'h0);
    chk("R1 irq", {14'd0, tmr_irq}, 16'h0);

    // R10 write masks
    wr(A_MODE0, 16'hFFFF); rd(A_MODE0, v); chk("R10 mode mask", v, 16'hFF1E);
    wr(A_PSR0, 16'h01FF);  rd(A_PSR0, v);  chk("R10 psr mask", v, 16'h00FF);
    wr(A_CFG, 16'hFFFF);   rd(A_CFG, v);   chk("R10 cfg mask", v, 16'h0033);
    rd(4'h6, v); chk("R10 unmapped", v, 16'h0);

    // R5/R4 sweep of divider and clock-driven sources
    for (int sl = 0; sl < 2; sl++) begin
      for (int p = 0; p < 4; p++) begin
        for (int s = 0; s < 3; s++) begin
          int n, div;
          n = sl ? 600 : 100;
          div = (p + 1) * (s + 1) * (sl ? 16 : 1);
          wr(A_CFG, 16'h0023);
          wr(A_PSR0, 16'(p));
          wr(A_MODE0, mk_mode(s, 0, 0, sl ? 2 : 1));
          wr(A_REF0, 16'hFFFF);
          wr(A_CFG, 16'h0022);
          wr(A_CFG, 16'h0020);
          wait_n(n);
          rd(A_CNT0, v);
          chk($sformatf("R5 R4 p=%0d s=%0d slow=%0d", p, s, sl), v, 16'(n / div));
        end
      end
    end

    // R4 source 3 gives no pulses
    wr(A_CFG, 16'h0023); wr(A_PSR0, 0); wr(A_MODE0, mk_mode(0, 0, 0, 3));
    wr(A_CFG, 16'h0022); wr(A_CFG, 16'h0020);
    wait_n(20); rd(A_CNT0, v); chk("R4 source none", v, 16'h0);

    // R4 external cascade pulses on timer 0
    wr(A_CFG, 16'h0023); wr(A_MODE0, mk_mode(0, 0, 0, 0));
    wr(A_CFG, 16'h0022); wr(A_CFG, 16'h0020);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); casc_in = 1'b1;
      @(negedge clk); casc_in = 1'b0;
      wait_n(3);
    end
    rd(A_CNT0, v); chk("R4 casc_in count", v, 16'd5);

    // R4 chain: timer 1 counts timer 0 restarts (period 3)
    wr(A_CFG, 16'h0033);
    wr(A_MODE0, mk_mode(0, 0, 1, 1)); wr(A_REF0, 16'd2); wr(A_PSR0, 0);
    wr(A_MODE1, mk_mode(0, 0, 0, 0)); wr(A_REF1, 16'hFFFF);
    wr(A_CFG, 16'h0022); wr(A_CFG, 16'h0000);
    wait_n(30);
    rd(A_CNT1, v); chk("R4 chain t1", v, 16'd10);
    rd(A_CNT0, v); chk("R6 t0 period 3", v, 16'd0);

    // R2 timer 1 reset bit 4, timer 0 stop bit 1
    wr(A_CFG, 16'h0012);
    wait_n(1);
    rd(A_CNT1, v); chk("R2 t1 reset bit4", v, 16'h0);
    rd(A_CNT0, v); wait_n(5); rd(A_CNT0, v2); chk("R2 t0 stop bit1", v2, v);

    // R6 restart with ref 4, R9 irq, R8 flag
    wr(A_CFG, 16'h0023); wr(A_PSR0, 0);
    wr(A_MODE0, mk_mode(0, 1, 1, 1)); wr(A_REF0, 16'd4);
    wr(A_CFG, 16'h0022); wr(A_CFG, 16'h0020);
    wait_n(3);
    rd(A_CNT0, v); chk("R6 cnt before match", v, 16'd3);
    rd(A_EVT0, v); chk("R6 no flag before match", v, 16'h0);
    wait_n(1);
    rd(A_CNT0, v); chk("R6 cnt at ref", v, 16'd4);
    rd(A_EVT0, v); chk("R8 flag at bit1", v, 16'h0002);
    chk("R9 irq high", {15'd0, tmr_irq[0]}, 16'd1);
    wait_n(1);
    rd(A_CNT0, v); chk("R6 restart to 0", v, 16'd0);
    wait_n(7);
    rd(A_CNT0, v); chk("R6 cnt mod 5", v, 16'd2);
    wr(A_EVT0, 16'h0000);
    rd(A_EVT0, v); chk("R8 zero write no effect", v, 16'h0002);
    wr(A_CFG, 16'h0022);
    wr(A_EVT0, 16'hFFFF);
    rd(A_EVT0, v); chk("R8 clear by one", v, 16'h0);
    chk("R9 irq low after clear", {15'd0, tmr_irq[0]}, 16'd0);

    // R9 interrupt disabled
    wr(A_CNT0, 16'd0); wr(A_MODE0, mk_mode(0, 0, 1, 1));
    wr(A_CFG, 16'h0020);
    wait_n(4);
    rd(A_EVT0, v); chk("R9 flag set", v, 16'h0002);
    chk("R9 irq masked", {15'd0, tmr_irq[0]}, 16'd0);

    // R3 reset bit clears state, keeps mode and ref
    wr(A_CFG, 16'h0021);
    wait_n(1);
    rd(A_CNT0, v);  chk("R3 cnt held", v, 16'h0);
    rd(A_EVT0, v);  chk("R3 evt held", v, 16'h0);
    rd(A_MODE0, v); chk("R3 mode kept", v, 16'h000A);
    rd(A_REF0, v);  chk("R3 ref kept", v, 16'd4);
    wr(A_CNT0, 16'h1234);
    rd(A_CNT0, v);  chk("R11 write ignored in reset", v, 16'h0);

    // R7 free-run rollover, R11 counter load
    wr(A_CFG, 16'h0023); wr(A_MODE0, mk_mode(0, 0, 0, 1)); wr(A_REF0, 16'd2);
    wr(A_CFG, 16'h0022);
    wr(A_CNT0, 16'hFFFD);
    rd(A_CNT0, v); chk("R11 counter load", v, 16'hFFFD);
    wr(A_CFG, 16'h0020);
    wait_n(2);
    rd(A_CNT0, v); chk("R7 at FFFF", v, 16'hFFFF);
    wait_n(1);
    rd(A_CNT0, v); chk("R7 rollover", v, 16'h0000);
    rd(A_EVT0, v); chk("R7 no flag on rollover", v, 16'h0);
    wait_n(2);
    rd(A_CNT0, v); chk("R7 reaches ref", v, 16'd2);
    rd(A_EVT0, v); chk("R7 flag at ref", v, 16'h0002);
    wait_n(3);
    rd(A_CNT0, v); chk("R7 passes ref", v, 16'd5);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule